// File: doc/BRIEF.md
# Dual-Bank Color Matrix Remap

This block is a gamut remap stage for RGB pixels. Each output channel is an affine mix of the three input channels: three signed coefficients scale red, green and blue, and a fourth signed term adds a fixed offset. Twelve coefficients make up one matrix. The block holds two complete matrices, bank A and bank B, so software can fill the idle bank while the other is processing pixels.

Configuration arrives on a simple write port. Each bank takes six 32-bit words, with two coefficients in each word. A control word sets the requested mode (bypass, bank A, bank B or a reserved code) and selects how coefficient words are read as fixed point. The request only reaches the pixel path on a frame-start pulse, which keeps a frame from using a mix of two matrices. A current-mode output shows which mode is live, so software can pick the idle bank: when A is live it loads B and requests B, and otherwise it loads A and requests A.

Pixels pass through a two-stage pipeline. The first stage multiplies and accumulates. The second stage rounds, adds the offset and clamps the result to the unsigned pixel range.

Top module: `color_remap_dual`

## Requirements
- R1: After reset, cur_mode_o is 0 (bypass) and pix_valid_o is 0.
- R2: Word addresses 0 to 5 hold bank A and addresses 6 to 11 hold bank B. Word k of a bank carries coefficient 2k in bits [15:0] and coefficient 2k+1 in bits [31:16]. Coefficients are numbered row-major, C11 C12 C13 C14 C21 … C34, where Cr1..Cr3 multiply red, green and blue for output row r and Cr4 is that row's offset.
- R3: Address 12 is the control word. Bits [1:0] hold the requested mode (0 bypass, 1 bank A, 2 bank B, 3 reserved). Bit 4 holds the requested format (0: coefficients are S2.13; 1: coefficients are S3.12).
- R4: The requested mode and format become current only on the clock edge where frame_start_i is high. At every other edge cur_mode_o keeps its value.
- R5: In bypass mode each output channel equals its input channel.
- R6: In bank modes, output row r is floor((Cr1·R + Cr2·G + Cr3·B + 2^(F-1)) / 2^F) + Cr4. Coefficients are 16-bit two's complement, F is 13 in format 0 and 12 in format 1, and the offset is in output LSB units.
- R7: Results below 0 are clamped to 0, and results above 2^PIX_W−1 are clamped to 2^PIX_W−1.
- R8: pix_valid_o follows pix_valid_i two clock edges later, and the data in that cycle belongs to that input pixel.
- R9: Writing the bank that is not live leaves the output unchanged.
- R10: In reserved mode 3, cur_mode_o reads 3 and pixels pass through as in bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W (4) | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| frame_start_i | input | 1 | Frame-start pulse that applies the requested mode and format |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | PIX_W (10) | Input red |
| pix_g_i | input | PIX_W (10) | Input green |
| pix_b_i | input | PIX_W (10) | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | PIX_W (10) | Output red |
| pix_g_o | output | PIX_W (10) | Output green |
| pix_b_o | output | PIX_W (10) | Output blue |
| cur_mode_o | output | 2 | Mode currently in effect |

## Verification
The hardest case to reach is a configuration change that must not disturb the output. That means a new request waiting for its frame-start pulse, or writes going into the bank that is not live. The stimulus first requests a mode and sends pixels before the pulse, which must still come out under the old mode. It then fills bank B while bank A is live and sends pixels, which must still match bank A. Only then does it pulse frame start and check that the outputs switch. The same bank is later run in both formats, which exercises the rounding and the clamping at both ends of the pixel range.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_BANK_A = 2'd1,
    MODE_BANK_B = 2'd2,
    MODE_RSVD   = 2'd3
  } remap_mode_e;

  localparam int unsigned COEF_W     = 16;
  localparam int unsigned NUM_ROWS   = 3;
  localparam int unsigned ROW_COEFS  = 4;
  localparam int unsigned NUM_COEF   = NUM_ROWS * ROW_COEFS;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BANK_WORDS = NUM_COEF * COEF_W / WORD_W;
  localparam int unsigned NUM_BANKS  = 2;
endpackage

// File: rtl/remap_coef_bank.sv
module remap_coef_bank
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BASE   = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [NUM_COEF*COEF_W-1:0]   coef_o
);
  logic [BANK_WORDS-1:0][WORD_W-1:0] word_q;

  for (genvar w = 0; w < BANK_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(BASE + w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         word_q[w] <= '0;
      else if (we_i && (addr_i == WADDR))  word_q[w] <= wdata_i;
    end
  end

  // low half holds the even coefficient
  assign coef_o = word_q;
endmodule

// File: rtl/remap_mode_ctrl.sv
module remap_mode_ctrl
  import remap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [1:0]  ctrl_mode_i,
  input  logic        ctrl_fmt_i,
  input  logic        frame_start_i,
  output remap_mode_e req_mode_o,
  output remap_mode_e cur_mode_o,
  output logic        cur_fmt_o
);
  remap_mode_e req_mode_q, cur_mode_q;
  logic        req_fmt_q, cur_fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_mode_q <= MODE_BYPASS;
      req_fmt_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      req_mode_q <= remap_mode_e'(ctrl_mode_i);
      req_fmt_q  <= ctrl_fmt_i;
    end
  end

  // staged: request only reaches the pixel path at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_mode_q <= MODE_BYPASS;
      cur_fmt_q  <= 1'b0;
    end else if (frame_start_i) begin
      cur_mode_q <= req_mode_q;
      cur_fmt_q  <= req_fmt_q;
    end
  end

  assign req_mode_o = req_mode_q;
  assign cur_mode_o = cur_mode_q;
  assign cur_fmt_o  = cur_fmt_q;
endmodule

// File: rtl/remap_row.sv
module remap_row
  import remap_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned FRAC_A = 13,
  parameter int unsigned FRAC_B = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fmt_i,
  input  logic                          bypass_i,
  input  logic [ROW_COEFS*COEF_W-1:0]   coef_i,
  input  logic [3*PIX_W-1:0]            pix_i,
  input  logic [PIX_W-1:0]              thru_i,
  output logic [PIX_W-1:0]              res_o
);
  localparam int unsigned PRD_W = COEF_W + PIX_W + 1;
  localparam int unsigned ACC_W = PRD_W + 2;
  localparam int unsigned SUM_W = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] RND_A = SUM_W'(2 ** (FRAC_A - 1));
  localparam logic signed [SUM_W-1:0] RND_B = SUM_W'(2 ** (FRAC_B - 1));
  localparam logic signed [SUM_W-1:0] MAX_V = {{(SUM_W-PIX_W){1'b0}}, {PIX_W{1'b1}}};

  logic signed [ACC_W-1:0]  acc_d, acc_q;
  logic signed [COEF_W-1:0] off_q;
  logic                     fmt_q, byp_q;
  logic [PIX_W-1:0]         thru_q, res_q;

  always_comb begin
    acc_d = '0;
    for (int j = 0; j < 3; j++) begin
      acc_d = acc_d + ACC_W'($signed(coef_i[COEF_W*j +: COEF_W]))
                    * ACC_W'($signed({1'b0, pix_i[PIX_W*j +: PIX_W]}));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      off_q  <= '0;
      fmt_q  <= 1'b0;
      byp_q  <= 1'b1;
      thru_q <= '0;
    end else begin
      acc_q  <= acc_d;
      off_q  <= $signed(coef_i[COEF_W*3 +: COEF_W]);
      fmt_q  <= fmt_i;
      byp_q  <= bypass_i;
      thru_q <= thru_i;
    end
  end

  logic signed [SUM_W-1:0] rnd_sum, scaled, total;
  logic [PIX_W-1:0]        clamped;

  always_comb begin
    rnd_sum = SUM_W'(acc_q) + (fmt_q ? RND_B : RND_A);
    scaled  = fmt_q ? (rnd_sum >>> FRAC_B) : (rnd_sum >>> FRAC_A);
    total   = scaled + SUM_W'(off_q);
    if (total < 0)           clamped = '0;
    else if (total > MAX_V)  clamped = '1;
    else                     clamped = total[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= byp_q ? thru_q : clamped;
  end

  assign res_o = res_q;
endmodule

// File: rtl/color_remap_dual.sv
module color_remap_dual
  import remap_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              frame_start_i,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix_r_i,
  input  logic [PIX_W-1:0]  pix_g_i,
  input  logic [PIX_W-1:0]  pix_b_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix_r_o,
  output logic [PIX_W-1:0]  pix_g_o,
  output logic [PIX_W-1:0]  pix_b_o,
  output logic [1:0]        cur_mode_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_BANKS * BANK_WORDS);
  localparam int unsigned ROW_BITS = ROW_COEFS * COEF_W;

  logic [NUM_BANKS-1:0][NUM_COEF*COEF_W-1:0] bank_coef;
  logic [NUM_COEF*COEF_W-1:0]                live_coef;
  remap_mode_e                               req_mode, cur_mode;
  logic                                      cur_fmt, bypass;
  logic [3*PIX_W-1:0]                        pix_in;
  logic [3*PIX_W-1:0]                        pix_out;
  logic [1:0]                                vld_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    remap_coef_bank #(.ADDR_W(ADDR_W), .BASE(b * BANK_WORDS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .addr_i  (cfg_addr_i),
      .wdata_i (cfg_wdata_i),
      .coef_o  (bank_coef[b])
    );
  end

  remap_mode_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (cfg_we_i && (cfg_addr_i == CTRL_ADDR)),
    .ctrl_mode_i   (cfg_wdata_i[1:0]),
    .ctrl_fmt_i    (cfg_wdata_i[4]),
    .frame_start_i (frame_start_i),
    .req_mode_o    (req_mode),
    .cur_mode_o    (cur_mode),
    .cur_fmt_o     (cur_fmt)
  );

  assign live_coef = (cur_mode == MODE_BANK_B) ? bank_coef[1] : bank_coef[0];
  assign bypass    = (cur_mode == MODE_BYPASS) || (cur_mode == MODE_RSVD);
  assign pix_in    = {pix_b_i, pix_g_i, pix_r_i};

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    remap_row #(.PIX_W(PIX_W)) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fmt_i    (cur_fmt),
      .bypass_i (bypass),
      .coef_i   (live_coef[ROW_BITS*r +: ROW_BITS]),
      .pix_i    (pix_in),
      .thru_i   (pix_in[PIX_W*r +: PIX_W]),
      .res_o    (pix_out[PIX_W*r +: PIX_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[0], pix_valid_i};
  end

  assign pix_valid_o = vld_q[1];
  assign pix_r_o     = pix_out[0 +: PIX_W];
  assign pix_g_o     = pix_out[PIX_W +: PIX_W];
  assign pix_b_o     = pix_out[2*PIX_W +: PIX_W];
  assign cur_mode_o  = cur_mode;
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int unsigned PIX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             pix_valid_i,
  input logic             pix_valid_o,
  input logic [PIX_W-1:0] pix_r_o,
  input logic [PIX_W-1:0] pix_g_o,
  input logic [PIX_W-1:0] pix_b_o,
  input logic [1:0]       cur_mode_o,
  input logic [1:0]       req_mode_i
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 0) |-> (cur_mode_o == 2'd0 && !pix_valid_o));

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 0 && !frame_start_i) |=> $stable(cur_mode_o));

  // R4
  mode_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cur_mode_o == $past(req_mode_i)));

  // R8
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2) |-> (pix_valid_o == $past(pix_valid_i, 2)));

  // R7
  known_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !$isunknown({pix_r_o, pix_g_o, pix_b_o}));
endmodule

bind color_remap_dual remap_chk #(.PIX_W(PIX_W)) u_remap_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .pix_valid_i   (pix_valid_i),
  .pix_valid_o   (pix_valid_o),
  .pix_r_o       (pix_r_o),
  .pix_g_o       (pix_g_o),
  .pix_b_o       (pix_b_o),
  .cur_mode_o    (cur_mode_o),
  .req_mode_i    (req_mode)
);

// File: tb/color_remap_dual_test.sv
`timescale 1ns/1ps
module color_remap_dual_test;
  localparam int PW   = 10;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic fs = 1'b0, vin = 1'b0;
  logic [PW-1:0] ri = '0, gi = '0, bi = '0;
  logic vout;
  logic [PW-1:0] ro, go, bo;
  logic [1:0] cmode;

  color_remap_dual uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .frame_start_i(fs), .pix_valid_i(vin),
    .pix_r_i(ri), .pix_g_i(gi), .pix_b_i(bi), .pix_valid_o(vout),
    .pix_r_o(ro), .pix_g_o(go), .pix_b_o(bo), .cur_mode_o(cmode)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int bank_a[12], bank_b[12];
  int req_m = 0, req_f = 0, cur_m = 0, cur_f = 0;

  typedef struct { int r; int g; int b; string tag; } exp_t;
  exp_t q[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(int row, int pr, int pg, int pb);
    int c[12];
    int f;
    longint acc, s;
    if (cur_m == 0 || cur_m == 3) return (row == 0) ? pr : (row == 1) ? pg : pb;
    for (int i = 0; i < 12; i++) c[i] = (cur_m == 1) ? bank_a[i] : bank_b[i];
    f = cur_f ? 12 : 13;
    acc = longint'(c[row*4]) * pr + longint'(c[row*4+1]) * pg + longint'(c[row*4+2]) * pb;
    s = ((acc + (longint'(1) <<< (f - 1))) >>> f) + c[row*4+3];
    if (s < 0) s = 0;
    if (s > PMAX) s = PMAX;
    return int'(s);
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R2: word k = {coef 2k+1, coef 2k}, bank B words start at 6
  task automatic load_bank(int b);
    for (int w = 0; w < 6; w++) begin
      if (b == 0) wr(w,     {16'(bank_a[2*w+1]), 16'(bank_a[2*w])});
      else        wr(6 + w, {16'(bank_b[2*w+1]), 16'(bank_b[2*w])});
    end
  endtask

  // R3: mode in [1:0], format in bit 4
  task automatic set_ctrl(int m, int f);
    wr(12, (32'(f) << 4) | 32'(m));
    req_m = m; req_f = f;
  endtask

  task automatic frame_start();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    cur_m = req_m; cur_f = req_f;
  endtask

  task automatic send(int pr, int pg, int pb, string tag);
    exp_t e;
    @(negedge clk);
    vin = 1'b1; ri = PW'(pr); gi = PW'(pg); bi = PW'(pb);
    e.r = model(0, pr, pg, pb); e.g = model(1, pr, pg, pb); e.b = model(2, pr, pg, pb);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    vin = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && vout) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 actual valid expected none");
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " red"},   int'(ro), e.r);
        check({e.tag, " green"}, int'(go), e.g);
        check({e.tag, " blue"},  int'(bo), e.b);
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cur_mode", int'(cmode), 0);
    check("R1 valid", int'(vout), 0);

    // R5 bypass
    send(1023, 0, 517, "R5");
    send(1, 2, 3, "R5");
    drain();

    // R2 load bank A: row0 G, row1 R+5, row2 0.5R+0.5G-3
    bank_a = '{0, 8192, 0, 0,  8192, 0, 0, 5,  4096, 4096, 0, -3};
    load_bank(0);
    set_ctrl(1, 0);
    check("R4 staged mode", int'(cmode), 0);
    send(300, 400, 500, "R4 pre-switch");
    drain();
    frame_start();
    check("R4 applied mode", int'(cmode), 1);
    send(5, 0, 0, "R6 round");
    send(7, 0, 9, "R6 round");
    send(1000, 600, 3, "R2 bank A");
    drain();

    // R9 fill idle bank B while A is live
    bank_b = '{16384, 0, 0, 100,  0, -8192, 0, 0,  0, 0, 8192, -2000};
    load_bank(1);
    send(1000, 600, 3, "R9 idle write");
    drain();
    set_ctrl(2, 0);
    frame_start();
    check("R4 bank B mode", int'(cmode), 2);
    send(1000, 10, 1023, "R7 clamp");
    send(20, 0, 1010, "R7 clamp");
    drain();

    // format 1: S3.12
    set_ctrl(2, 1);
    frame_start();
    send(1000, 10, 1023, "R6 fmt1");
    send(20, 0, 1010, "R6 fmt1");
    drain();

    // R10 reserved
    set_ctrl(3, 0);
    frame_start();
    check("R10 cur_mode", int'(cmode), 3);
    send(11, 222, 933, "R10 passthru");
    drain();

    // R8 latency: one edge in, no valid; two edges, valid
    @(negedge clk);
    vin = 1'b1; ri = 10'd44; gi = 10'd55; bi = 10'd66;
    begin
      exp_t e;
      e.r = 44; e.g = 55; e.b = 66; e.tag = "R8";
      q.push_back(e);
    end
    @(posedge clk); #1;
    check("R8 one edge", int'(vout), 0);
    @(negedge clk); vin = 1'b0;
    @(posedge clk); #1;
    check("R8 two edges", int'(vout), 1);
    drain();

    check("R8 queue empty", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule